// File: doc/BRIEF.md
# Hardwired Five-Step Instruction Sequencer

This block is the hardwired control section of a simple processor whose instructions all pass through the same five steps. The steps are fetch, decode and register read, ALU operation, memory access and write-back. A step counter records how far the current instruction has progressed. Combinational logic looks at the step, the opcode field of the instruction register, the ALU equality flag and the memory-completion input. From these it produces the datapath multiplexer selects, the ALU function, the memory request lines and the write enables for the program counter, the instruction register and the register file.

Memory accesses may take one cycle or many. The sequencer holds its step while a fetch or a data access is still outstanding. During that wait it keeps the request asserted and blocks every write enable. Steps that issue no memory request move on unconditionally, one clock per step.

The sequencer handles six instruction kinds: load, store, register add, add immediate, branch-if-equal and indirect call through a register. Any other opcode is fetched and then passes through the remaining steps without effect. The step counter can be built as a binary counter or as a one-hot ring, and the outputs are the same either way.

Top module: `hw_step_ctrl`

## Requirements
- R1: While reset is asserted, and right after it is released, `step` reads 1 (fetch). With `mfc` low, `memRd` is 1 and `pcWe`, `irWe`, `rfWe` and `memWr` are 0.
- R2: `step` takes the values 1 to 5. It advances by one each clock and wraps from 5 back to 1, except while a memory request is waiting.
- R3: In step 1, `memRd`=1 and `addrSel`=0 (PC). When `mfc` is high, `irWe`=1, `pcWe`=1 and `pcSel`=0 (increment). When `mfc` is low, the step holds and neither enable is asserted.
- R4: In step 4, a load (opcode 6'h01) drives `memRd`=1, `addrSel`=1 (RZ) and `ySel`=1 (memory data). A store (opcode 6'h02) drives `memWr`=1 and `addrSel`=1. Both hold step 4 until `mfc` is high.
- R5: In step 4, add (6'h03), add-immediate (6'h04), branch (6'h05) and call (6'h06) issue no memory request and advance whatever the value of `mfc`. Add and add-immediate select `ySel`=0 (ALU result).
- R6: In step 3, load, store and add-immediate drive `bSel`=1 (immediate) and `aluFn`=0 (add). Register add drives `bSel`=0 and `aluFn`=0.
- R7: In step 3, branch-if-equal drives `bSel`=0 and `aluFn`=1 (subtract/compare). It asserts `pcWe` with `pcSel`=1 (branch target) only when `aluEq` is high.
- R8: Call-register asserts `pcWe` with `pcSel`=2 (register) in step 3. It selects `ySel`=2 (return address) in step 4, and asserts `rfWe` with `linkSel`=1 in step 5.
- R9: `rfWe` is asserted only in step 5, and only for load, add, add-immediate and call. Store and branch write nothing in step 5.
- R10: Whenever a memory request is outstanding with `mfc` low, `pcWe`, `irWe` and `rfWe` are all 0 and the request stays asserted.
- R11: An opcode outside the six listed produces no write enable and no memory request in steps 2 to 5.
- R12: The binary and one-hot step encodings give identical outputs cycle for cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opcode | input | OPC_W | Opcode field of the instruction register |
| aluEq | input | 1 | ALU reports both operands equal |
| mfc | input | 1 | Memory function completed |
| step | output | 3 | Current step, 1 to 5 |
| pcWe | output | 1 | Program counter write enable |
| pcSel | output | 2 | PC source: 0 increment, 1 branch target, 2 register |
| irWe | output | 1 | Instruction register write enable |
| rfWe | output | 1 | Register file write enable |
| linkSel | output | 1 | Destination is the link register |
| memRd | output | 1 | Memory read request |
| memWr | output | 1 | Memory write request |
| addrSel | output | 1 | Memory address source: 0 PC, 1 RZ |
| bSel | output | 1 | ALU B operand: 0 register, 1 immediate |
| aluFn | output | 2 | ALU function: 0 add, 1 subtract |
| ySel | output | 2 | RY source: 0 ALU, 1 memory, 2 return address |

## Verification
The bench builds two copies of the block from the same stimulus. One uses the default binary step counter and the other sets `ONE_HOT_STEP`=1, so both generate branches are exercised and compared against one expectation. Both use the default 6-bit opcode values. The stimulus inserts fetch and data-access waits of several cycles and drives `mfc` high in steps that make no request. It also covers the branch with the equality flag both set and clear, and an undefined opcode.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

  localparam int NUM_STEPS = 5;
  localparam int STEP_W    = 3;

  typedef enum logic [STEP_W-1:0] {
    ST_FETCH  = 3'd1,
    ST_DECODE = 3'd2,
    ST_ALU    = 3'd3,
    ST_MEM    = 3'd4,
    ST_WB     = 3'd5
  } step_e;

  typedef enum logic [2:0] {
    OP_NONE, OP_LOAD, OP_STORE, OP_ADD, OP_ADDI, OP_BEQ, OP_CALLR
  } op_e;

  typedef enum logic [1:0] {
    PC_INC    = 2'd0,
    PC_BRANCH = 2'd1,
    PC_REG    = 2'd2
  } pc_sel_e;

  typedef enum logic [1:0] {
    Y_ALU = 2'd0,
    Y_MEM = 2'd1,
    Y_RET = 2'd2
  } y_sel_e;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1
  } alu_fn_e;

  // strobes toward the datapath
  typedef struct packed {
    logic    pcWe;
    pc_sel_e pcSel;
    logic    irWe;
    logic    rfWe;
    logic    linkSel;
    logic    memRd;
    logic    memWr;
    logic    addrSel;
    logic    bSel;
    alu_fn_e aluFn;
    y_sel_e  ySel;
  } ctl_word_t;

  // strobes toward the step sequencer
  typedef struct packed {
    logic advance;
  } seq_strobe_t;

endpackage

// File: rtl/op_decode.sv
module op_decode
  import ctl_pkg::*;
#(
  parameter int              OPC_W     = 6,
  parameter logic [OPC_W-1:0] OPC_LOAD  = 6'h01,
  parameter logic [OPC_W-1:0] OPC_STORE = 6'h02,
  parameter logic [OPC_W-1:0] OPC_ADD   = 6'h03,
  parameter logic [OPC_W-1:0] OPC_ADDI  = 6'h04,
  parameter logic [OPC_W-1:0] OPC_BEQ   = 6'h05,
  parameter logic [OPC_W-1:0] OPC_CALLR = 6'h06
) (
  input  logic [OPC_W-1:0] opcode,
  output op_e              op
);

  always_comb begin
    if (opcode == OPC_LOAD)       op = OP_LOAD;
    else if (opcode == OPC_STORE) op = OP_STORE;
    else if (opcode == OPC_ADD)   op = OP_ADD;
    else if (opcode == OPC_ADDI)  op = OP_ADDI;
    else if (opcode == OPC_BEQ)   op = OP_BEQ;
    else if (opcode == OPC_CALLR) op = OP_CALLR;
    else                          op = OP_NONE;
  end

endmodule

// File: rtl/step_seq.sv
module step_seq
  import ctl_pkg::*;
#(
  parameter bit ONE_HOT_STEP = 1'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  seq_strobe_t strobe,
  output step_e       step
);

  generate
    if (ONE_HOT_STEP) begin : g_ring
      logic [NUM_STEPS-1:0] ringQ;

      always_ff @(posedge clk) begin
        if (!rstN)               ringQ <= NUM_STEPS'(1);
        else if (strobe.advance) ringQ <= {ringQ[NUM_STEPS-2:0], ringQ[NUM_STEPS-1]};
      end

      always_comb begin
        step = ST_FETCH;
        for (int i = 0; i < NUM_STEPS; i++) begin
          if (ringQ[i]) step = step_e'(STEP_W'(i + 1));
        end
      end
    end else begin : g_bin
      step_e stepQ;

      always_ff @(posedge clk) begin
        if (!rstN) begin
          stepQ <= ST_FETCH;
        end else if (strobe.advance) begin
          if (stepQ == ST_WB) stepQ <= ST_FETCH;
          else                stepQ <= step_e'(stepQ + STEP_W'(1));
        end
      end

      assign step = stepQ;
    end
  endgenerate

endmodule

// File: rtl/strobe_gen.sv
module strobe_gen
  import ctl_pkg::*;
(
  input  step_e       step,
  input  op_e         op,
  input  logic        aluEq,
  input  logic        mfc,
  output ctl_word_t   cw,
  output seq_strobe_t seq
);

  always_comb begin
    cw          = '0;
    seq.advance = 1'b1;
    case (step)
      ST_FETCH: begin
        cw.memRd   = 1'b1;
        cw.addrSel = 1'b0;
        if (mfc) begin
          cw.irWe  = 1'b1;
          cw.pcWe  = 1'b1;
          cw.pcSel = PC_INC;
        end else begin
          seq.advance = 1'b0;
        end
      end
      ST_DECODE: begin
        // operands latch into always-enabled inter-step registers
      end
      ST_ALU: begin
        case (op)
          OP_LOAD, OP_STORE, OP_ADDI: begin
            cw.bSel  = 1'b1;
            cw.aluFn = ALU_ADD;
          end
          OP_ADD: cw.aluFn = ALU_ADD;
          OP_BEQ: begin
            cw.aluFn = ALU_SUB;
            if (aluEq) begin
              cw.pcWe  = 1'b1;
              cw.pcSel = PC_BRANCH;
            end
          end
          OP_CALLR: begin
            cw.pcWe  = 1'b1;
            cw.pcSel = PC_REG;
          end
          default: ;
        endcase
      end
      ST_MEM: begin
        case (op)
          OP_LOAD: begin
            cw.memRd    = 1'b1;
            cw.addrSel  = 1'b1;
            cw.ySel     = Y_MEM;
            seq.advance = mfc;
          end
          OP_STORE: begin
            cw.memWr    = 1'b1;
            cw.addrSel  = 1'b1;
            seq.advance = mfc;
          end
          OP_CALLR: cw.ySel = Y_RET;
          default:  cw.ySel = Y_ALU;
        endcase
      end
      ST_WB: begin
        case (op)
          OP_LOAD, OP_ADD, OP_ADDI: cw.rfWe = 1'b1;
          OP_CALLR: begin
            cw.rfWe    = 1'b1;
            cw.linkSel = 1'b1;
          end
          default: ;
        endcase
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/hw_step_ctrl.sv
module hw_step_ctrl
  import ctl_pkg::*;
#(
  parameter int               OPC_W        = 6,
  parameter logic [OPC_W-1:0] OPC_LOAD     = 6'h01,
  parameter logic [OPC_W-1:0] OPC_STORE    = 6'h02,
  parameter logic [OPC_W-1:0] OPC_ADD      = 6'h03,
  parameter logic [OPC_W-1:0] OPC_ADDI     = 6'h04,
  parameter logic [OPC_W-1:0] OPC_BEQ      = 6'h05,
  parameter logic [OPC_W-1:0] OPC_CALLR    = 6'h06,
  parameter bit               ONE_HOT_STEP = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [OPC_W-1:0] opcode,
  input  logic             aluEq,
  input  logic             mfc,
  output logic [2:0]       step,
  output logic             pcWe,
  output logic [1:0]       pcSel,
  output logic             irWe,
  output logic             rfWe,
  output logic             linkSel,
  output logic             memRd,
  output logic             memWr,
  output logic             addrSel,
  output logic             bSel,
  output logic [1:0]       aluFn,
  output logic [1:0]       ySel
);

  step_e       stepNow;
  op_e         opNow;
  ctl_word_t   cw;
  seq_strobe_t seqStb;

  op_decode #(
    .OPC_W(OPC_W), .OPC_LOAD(OPC_LOAD), .OPC_STORE(OPC_STORE),
    .OPC_ADD(OPC_ADD), .OPC_ADDI(OPC_ADDI), .OPC_BEQ(OPC_BEQ),
    .OPC_CALLR(OPC_CALLR)
  ) u_dec (
    .opcode(opcode),
    .op    (opNow)
  );

  step_seq #(.ONE_HOT_STEP(ONE_HOT_STEP)) u_seq (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(seqStb),
    .step  (stepNow)
  );

  strobe_gen u_gen (
    .step (stepNow),
    .op   (opNow),
    .aluEq(aluEq),
    .mfc  (mfc),
    .cw   (cw),
    .seq  (seqStb)
  );

  assign step    = stepNow;
  assign pcWe    = cw.pcWe;
  assign pcSel   = cw.pcSel;
  assign irWe    = cw.irWe;
  assign rfWe    = cw.rfWe;
  assign linkSel = cw.linkSel;
  assign memRd   = cw.memRd;
  assign memWr   = cw.memWr;
  assign addrSel = cw.addrSel;
  assign bSel    = cw.bSel;
  assign aluFn   = cw.aluFn;
  assign ySel    = cw.ySel;

endmodule

// File: rtl/hw_step_ctrl_chk.sv
module hw_step_ctrl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       mfc,
  input logic [2:0] step,
  input logic       pcWe,
  input logic       irWe,
  input logic       rfWe,
  input logic       linkSel,
  input logic       memRd,
  input logic       memWr
);

  logic waiting;
  assign waiting = (memRd || memWr) && !mfc;

  a_r1_step_legal: assert property (@(posedge clk) disable iff (!rstN)
    (step >= 3'd1) && (step <= 3'd5));

  a_r2_step_advance: assert property (@(posedge clk) disable iff (!rstN)
    !waiting |=> step == (($past(step) == 3'd5) ? 3'd1 : $past(step) + 3'd1));

  a_r2_step_hold: assert property (@(posedge clk) disable iff (!rstN)
    waiting |=> $stable(step));

  a_r10_quiet_wait: assert property (@(posedge clk) disable iff (!rstN)
    waiting |-> !(pcWe || irWe || rfWe));

  a_r3_ir_in_fetch: assert property (@(posedge clk) disable iff (!rstN)
    irWe |-> (step == 3'd1) && mfc);

  a_r9_rf_in_wb: assert property (@(posedge clk) disable iff (!rstN)
    rfWe |-> step == 3'd5);

  a_r4_rd_wr_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr));

  a_r8_link_writes: assert property (@(posedge clk) disable iff (!rstN)
    linkSel |-> rfWe);

endmodule

bind hw_step_ctrl hw_step_ctrl_chk u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .mfc    (mfc),
  .step   (step),
  .pcWe   (pcWe),
  .irWe   (irWe),
  .rfWe   (rfWe),
  .linkSel(linkSel),
  .memRd  (memRd),
  .memWr  (memWr)
);

// File: tb/hw_step_ctrl_tb_top.sv
module hw_step_ctrl_tb_top;

  localparam logic [5:0] LD = 6'h01, ST = 6'h02, AD = 6'h03,
                         AI = 6'h04, BQ = 6'h05, CL = 6'h06, XX = 6'h3F;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [5:0] opcode = '0;
  logic aluEq = 1'b0;
  logic mfc = 1'b0;

  always #2 clk = ~clk;

  logic [2:0] stepA, stepB;
  logic pcWeA, irWeA, rfWeA, linkA, rdA, wrA, adA, bA;
  logic pcWeB, irWeB, rfWeB, linkB, rdB, wrB, adB, bB;
  logic [1:0] pcSelA, aluA, yA, pcSelB, aluB, yB;

  hw_step_ctrl dut_i (
    .clk(clk), .rstN(rstN), .opcode(opcode), .aluEq(aluEq), .mfc(mfc),
    .step(stepA), .pcWe(pcWeA), .pcSel(pcSelA), .irWe(irWeA), .rfWe(rfWeA),
    .linkSel(linkA), .memRd(rdA), .memWr(wrA), .addrSel(adA), .bSel(bA),
    .aluFn(aluA), .ySel(yA));

  hw_step_ctrl #(.ONE_HOT_STEP(1'b1)) dut_oh (
    .clk(clk), .rstN(rstN), .opcode(opcode), .aluEq(aluEq), .mfc(mfc),
    .step(stepB), .pcWe(pcWeB), .pcSel(pcSelB), .irWe(irWeB), .rfWe(rfWeB),
    .linkSel(linkB), .memRd(rdB), .memWr(wrB), .addrSel(adB), .bSel(bB),
    .aluFn(aluB), .ySel(yB));

  logic [16:0] obsA, obsB;
  assign obsA = {stepA, pcWeA, pcSelA, irWeA, rfWeA, linkA, rdA, wrA, adA, bA, aluA, yA};
  assign obsB = {stepB, pcWeB, pcSelB, irWeB, rfWeB, linkB, rdB, wrB, adB, bB, aluB, yB};

  int checks = 0;
  int fails = 0;
  logic [16:0] expQ[$];
  string tagQ[$];
  int mStep = 1;
  bit allDone = 1'b0;

  function automatic logic [16:0] model(int s, logic [5:0] o, logic eq, logic mv);
    logic pw = 0, iw = 0, rw = 0, lk = 0, rd = 0, wr = 0, ad = 0, b = 0;
    logic [1:0] ps = 0, fn = 0, y = 0;
    if (s == 1) begin
      rd = 1; pw = mv; iw = mv;
    end
    if (s == 3) begin
      b  = (o == LD) || (o == ST) || (o == AI);
      fn = (o == BQ) ? 2'd1 : 2'd0;
      if (o == BQ && eq) begin pw = 1; ps = 2'd1; end
      if (o == CL)       begin pw = 1; ps = 2'd2; end
    end
    if (s == 4) begin
      rd = (o == LD); wr = (o == ST); ad = (o == LD) || (o == ST);
      y  = (o == LD) ? 2'd1 : (o == CL) ? 2'd2 : 2'd0;
    end
    if (s == 5) begin
      rw = (o == LD) || (o == AD) || (o == AI) || (o == CL);
      lk = (o == CL);
    end
    return {3'(s), pw, ps, iw, rw, lk, rd, wr, ad, b, fn, y};
  endfunction

  function automatic string tagOf(int s, logic [5:0] o, logic mv);
    bit known = (o >= LD) && (o <= CL);
    if (!rstN) return "R1";
    if (s == 1) return mv ? "R3" : "R10";
    if (!known) return "R11";
    if (s == 2) return "R2";
    if (s == 3) return (o == BQ) ? "R7" : (o == CL) ? "R8" : "R6";
    if (s == 4) return (o == LD || o == ST) ? (mv ? "R4" : "R10") : "R5";
    return "R9";
  endfunction

  // driver: one cycle of stimulus plus its expectation
  task automatic cyc(input logic [5:0] o, input logic eq, input logic mv);
    bit wt;
    @(negedge clk);
    opcode = o; aluEq = eq; mfc = mv;
    expQ.push_back(model(mStep, o, eq, mv));
    tagQ.push_back(tagOf(mStep, o, mv));
    wt = (mStep == 1 || (mStep == 4 && (o == LD || o == ST))) && !mv;
    if (!rstN)    mStep = 1;
    else if (!wt) mStep = (mStep == 5) ? 1 : mStep + 1;
  endtask

  task automatic runInstr(input logic [5:0] o, input logic eq,
                          input int fetchWait, input int memWait);
    for (int i = 0; i < fetchWait; i++) cyc(o, eq, 1'b0);
    cyc(o, eq, 1'b1);
    cyc(o, eq, 1'b1);          // step 2 ignores mfc
    cyc(o, eq, 1'b0);          // step 3
    if (o == LD || o == ST) begin
      for (int i = 0; i < memWait; i++) cyc(o, eq, 1'b0);
      cyc(o, eq, 1'b1);
    end else begin
      cyc(o, eq, 1'b0);        // R5: no wait without a request
    end
    cyc(o, eq, 1'b1);          // step 5 ignores mfc
  endtask

  // monitor: pops expectations and compares both copies
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (expQ.size() > 0) begin
        logic [16:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        checks++;
        if (obsA !== e) begin
          fails++;
          $display("FAIL %s binary: actual %h expected %h", t, obsA, e);
        end
        checks++;
        if (obsB !== e) begin
          fails++;
          $display("FAIL R12 (%s) one-hot: actual %h expected %h", t, obsB, e);
        end
      end
    end
  end

  task automatic report();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!allDone) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      report();
    end
  end

  initial begin
    rstN = 1'b0;
    repeat (3) cyc(AD, 1'b0, 1'b0);     // R1 reset state
    rstN = 1'b1;
    cyc(AD, 1'b0, 1'b0);                // R1 after release, fetch waits
    cyc(AD, 1'b0, 1'b0);
    cyc(AD, 1'b0, 1'b1);                // fetch completes
    cyc(AD, 1'b0, 1'b0); cyc(AD, 1'b0, 1'b0);
    cyc(AD, 1'b0, 1'b1); cyc(AD, 1'b0, 1'b0);  // R2 back to step 1 after this
    runInstr(AI, 1'b0, 0, 0);           // R6
    runInstr(LD, 1'b0, 2, 3);           // R4 with waits
    runInstr(ST, 1'b1, 0, 2);           // R4 store
    runInstr(BQ, 1'b1, 1, 0);           // R7 taken
    runInstr(BQ, 1'b0, 0, 0);           // R7 not taken
    runInstr(CL, 1'b1, 0, 0);           // R8
    runInstr(XX, 1'b1, 0, 0);           // R11
    runInstr(LD, 1'b0, 0, 0);           // R4 one-cycle access
    runInstr(AD, 1'b1, 5, 0);           // R10 long fetch wait
    runInstr(ST, 1'b0, 0, 0);           // R9 store writes no register
    @(negedge clk);
    @(negedge clk);
    allDone = 1'b1;
    report();
  end

endmodule